// File: doc/BRIEF.md
# Bridge Output Mode and Fault Controller

This block is the digital control core of a two-channel bridge-tied class-D output stage. Each channel has a differential PWM input pair. The block turns each pair into high-side and low-side gate enables for the two half bridges of that channel. The PWM enables reach the gates only when the stage is awake, unmuted and past its turn-on delay, and no fault is latched. Otherwise every transistor is switched off and the stage is high-impedance.

Six comparator flags from the analog side are synchronised and filtered for glitches. They report: the hot edge of the temperature warning band, the cool edge of that band, critical over-temperature, overcurrent, power-rail undervoltage and logic-rail undervoltage. Any of the last four latches an error that forces high-impedance. The error clears only when mute goes low and then high again. The thermal warning follows the hot and cool comparators with hysteresis and does not stop operation. Both flags leave the block as pull-down enables for active-low open-drain pads, so several stages can share one wired-OR flag line.

Top module: `bridge_guard`

All inputs and outputs are plain level signals. The block has no data stream interface and exerts no back-pressure: the PWM inputs are sampled every cycle and never held off.

## Requirements
- R1: While `mute_n` is low, `hiz` is 1 and every bit of `hs_en` and `ls_en` is 0, in the same cycle and for any PWM input.
- R2: When `hiz` is 0, channel c drives half bridge 2c from `pwm_p[c]` and half bridge 2c+1 from `pwm_n[c]`. An input of 1 sets that half bridge's `hs_en` bit (output to supply). An input of 0 sets its `ls_en` bit (output to ground). So 00 is damped, 10 is positive, 01 is negative, and 11 drives both outputs to the supply.
- R3: While `standby_n` is low, `hiz` is 1. When `standby_n` rises, the logic wakes one edge later, and `hiz` stays 1 until `mute_n` is high and the turn-on delay has run.
- R4: From the awake muted state with no error, `hiz` falls exactly TURN_ON_CYC+1 rising edges after the first edge that samples `mute_n` high.
- R5: A fault on `temp_crit`, `over_cur`, `pwr_rail_low` or `logic_rail_low` sets `err_pull` to 1 and forces `hiz` to 1. Both stay set after the comparator drops.
- R6: A latched error clears only on an edge that samples `mute_n` high after an edge that sampled it low. If the fault is still present, the error latches again.
- R7: Each comparator input passes through a two-flop synchroniser. It is accepted only after it has been high for FILTER_CYC consecutive cycles. A pulse of FILTER_CYC-1 cycles has no effect on the flags or on `hiz`.
- R8: `warn_pull` sets when `temp_hot` is accepted and clears only when `temp_cool` is accepted. Between the two it holds its value. It does not force `hiz` and needs no mute toggle.
- R9: A fault accepted during the turn-on delay latches the error and stops the turn-on. `hiz` stays 1 until the error is cleared.
- R10: While either rail undervoltage comparator is held asserted, the stage never leaves high-impedance, even across mute toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Low: low-power standby, stage high-impedance |
| mute_n | input | 1 | Low: muted; a low-then-high toggle clears a latched error |
| pwm_p | input | NCH | Positive PWM input per channel |
| pwm_n | input | NCH | Negative PWM input per channel |
| temp_hot | input | 1 | Comparator: die above the warning-set temperature |
| temp_cool | input | 1 | Comparator: die below the warning-release temperature |
| temp_crit | input | 1 | Comparator: die above the shutdown temperature |
| over_cur | input | 1 | Comparator: output current above the peak limit |
| pwr_rail_low | input | 1 | Comparator: power rail below its operating threshold |
| logic_rail_low | input | 1 | Comparator: logic rail below its operating threshold |
| hs_en | output | 2*NCH | High-side gate enable per half bridge |
| ls_en | output | 2*NCH | Low-side gate enable per half bridge |
| hiz | output | 1 | 1 when every transistor is off |
| warn_pull | output | 1 | Pull-down enable for the active-low thermal warning pad |
| err_pull | output | 1 | Pull-down enable for the active-low error pad |

## Verification
The bench builds the block with NCH=2, TURN_ON_CYC=8 and FILTER_CYC=4. With two channels there are only 16 input codes, so the full decode table is swept both while running and while muted. The short turn-on delay allows the edge on which `hiz` falls to be checked exactly, after unmute and after a wake from standby. It also allows a fault to be injected in the middle of the ramp. With a four-cycle filter, the three-cycle and four-cycle pulses sit on either side of the acceptance boundary. Every fault source goes through the same sequence: latch, hold after the comparator drops, clear by toggle, and re-latch while the fault is still present.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_LIVE  = 2'd3
  } stage_t;

  // comparator slots in the filtered vector
  localparam int NCMP     = 6;
  localparam int CMP_HOT  = 0;
  localparam int CMP_COOL = 1;
  localparam int CMP_CRIT = 2;
  localparam int CMP_OC   = 3;
  localparam int CMP_UVP  = 4;
  localparam int CMP_UVL  = 5;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_t;

  function automatic leg_t leg_drive(input logic level, input logic off);
    leg_t r;
    r.hi = ~off & level;
    r.lo = ~off & ~level;
    return r;
  endfunction

endpackage

// File: rtl/bmf_glitch_filter.sv
module bmf_glitch_filter #(
  parameter int PERSIST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic accepted
);
  localparam int CW = $clog2(PERSIST + 1);

  logic          s1, s2;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      run_len <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!s2)
        run_len <= '0;
      else if (run_len != CW'(PERSIST))
        run_len <= run_len + 1'b1;
    end
  end

  assign accepted = (run_len == CW'(PERSIST));
endmodule

// File: rtl/bmf_flag_logic.sv
module bmf_flag_logic (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n,
  input  logic fault_any,
  input  logic hot_ok,
  input  logic cool_ok,
  output logic err_q,
  output logic warn_q
);
  logic mute_prev;
  logic rearm;

  assign rearm = mute_n & ~mute_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_prev <= 1'b0;
      err_q     <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      mute_prev <= mute_n;
      // a present fault wins over the re-arm toggle
      err_q <= fault_any | (err_q & ~rearm);
      if (hot_ok)
        warn_q <= 1'b1;
      else if (cool_ok)
        warn_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmf_sequencer.sv
module bmf_sequencer
  import bmf_pkg::*;
#(
  parameter int TURN_ON_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_n,
  input  logic mute_n,
  input  logic blocked,
  output logic live
);
  localparam int CW = $clog2(TURN_ON_CYC + 1);

  stage_t        st;
  logic [CW-1:0] ramp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_SLEEP;
      ramp_cnt <= '0;
    end else if (!standby_n) begin
      st       <= ST_SLEEP;
      ramp_cnt <= '0;
    end else begin
      unique case (st)
        ST_SLEEP: st <= ST_HOLD;
        ST_HOLD: begin
          ramp_cnt <= '0;
          if (mute_n && !blocked) st <= ST_RAMP;
        end
        ST_RAMP: begin
          if (!mute_n || blocked) begin
            st <= ST_HOLD;
          end else if (ramp_cnt == CW'(TURN_ON_CYC - 1)) begin
            st <= ST_LIVE;
          end else begin
            ramp_cnt <= ramp_cnt + 1'b1;
          end
        end
        ST_LIVE: if (!mute_n || blocked) st <= ST_HOLD;
        default: st <= ST_SLEEP;
      endcase
    end
  end

  assign live = (st == ST_LIVE);
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bmf_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TURN_ON_CYC = 40000,
  parameter int FILTER_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_n,
  input  logic             mute_n,
  input  logic [NCH-1:0]   pwm_p,
  input  logic [NCH-1:0]   pwm_n,
  input  logic             temp_hot,
  input  logic             temp_cool,
  input  logic             temp_crit,
  input  logic             over_cur,
  input  logic             pwr_rail_low,
  input  logic             logic_rail_low,
  output logic [2*NCH-1:0] hs_en,
  output logic [2*NCH-1:0] ls_en,
  output logic             hiz,
  output logic             warn_pull,
  output logic             err_pull
);
  localparam int NHB = 2 * NCH;

  logic [NCMP-1:0] cmp_raw, cmp_ok;
  logic            fault_any, err_q, live;

  assign cmp_raw[CMP_HOT]  = temp_hot;
  assign cmp_raw[CMP_COOL] = temp_cool;
  assign cmp_raw[CMP_CRIT] = temp_crit;
  assign cmp_raw[CMP_OC]   = over_cur;
  assign cmp_raw[CMP_UVP]  = pwr_rail_low;
  assign cmp_raw[CMP_UVL]  = logic_rail_low;

  for (genvar k = 0; k < NCMP; k++) begin : g_filt
    bmf_glitch_filter #(.PERSIST(FILTER_CYC)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (cmp_raw[k]),
      .accepted (cmp_ok[k])
    );
  end

  assign fault_any = |cmp_ok[CMP_UVL:CMP_CRIT];

  bmf_flag_logic u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_n    (mute_n),
    .fault_any (fault_any),
    .hot_ok    (cmp_ok[CMP_HOT]),
    .cool_ok   (cmp_ok[CMP_COOL]),
    .err_q     (err_q),
    .warn_q    (warn_pull)
  );

  bmf_sequencer #(.TURN_ON_CYC(TURN_ON_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_n (standby_n),
    .mute_n    (mute_n),
    .blocked   (err_q | fault_any),
    .live      (live)
  );

  assign err_pull = err_q;
  assign hiz      = ~mute_n | ~standby_n | ~live | err_q | fault_any;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    leg_t pos_leg, neg_leg;
    assign pos_leg = leg_drive(pwm_p[c], hiz);
    assign neg_leg = leg_drive(pwm_n[c], hiz);
    assign hs_en[2*c]   = pos_leg.hi;
    assign ls_en[2*c]   = pos_leg.lo;
    assign hs_en[2*c+1] = neg_leg.hi;
    assign ls_en[2*c+1] = neg_leg.lo;
  end

  if (NHB < 2) begin : g_bad_cfg
    initial $error("bridge_guard needs at least one channel");
  end
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int NHB = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           standby_n,
  input logic           mute_n,
  input logic           hiz,
  input logic [NHB-1:0] hs_en,
  input logic [NHB-1:0] ls_en,
  input logic           err_pull
);
  // R1
  mute_forces_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |-> hiz);

  // R1
  hiz_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |-> (hs_en == '0 && ls_en == '0));

  // R2
  legs_complementary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz |-> ((hs_en ^ ls_en) == '1 && (hs_en & ls_en) == '0));

  // R3
  standby_forces_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |-> hiz);

  // R4
  enable_after_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiz) |-> $past(mute_n) && $past(standby_n));

  // R5
  error_forces_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pull |-> hiz);

  // R6
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pull && !(mute_n && !$past(mute_n)) |=> err_pull);
endmodule

bind bridge_guard bridge_guard_chk #(.NHB(2*NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby_n (standby_n),
  .mute_n    (mute_n),
  .hiz       (hiz),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .err_pull  (err_pull)
);

// File: tb/bridge_guard_tb_top.sv
module bridge_guard_tb_top;
  localparam int NCH = 2;
  localparam int TON = 8;
  localparam int FLT = 4;
  localparam int NHB = 2 * NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_n = 1'b0, mute_n = 1'b0;
  logic [NCH-1:0] pwm_p = '0, pwm_n = '0;
  logic temp_hot = 0, temp_cool = 0, temp_crit = 0, over_cur = 0;
  logic pwr_rail_low = 0, logic_rail_low = 0;
  logic [NHB-1:0] hs_en, ls_en;
  logic hiz, warn_pull, err_pull;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bridge_guard #(.NCH(NCH), .TURN_ON_CYC(TON), .FILTER_CYC(FLT)) dut_i (
    .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .mute_n(mute_n),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .temp_crit(temp_crit), .over_cur(over_cur), .pwr_rail_low(pwr_rail_low),
    .logic_rail_low(logic_rail_low), .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz),
    .warn_pull(warn_pull), .err_pull(err_pull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fault(input int src, input logic v);
    case (src)
      0: temp_crit = v;
      1: over_cur = v;
      2: pwr_rail_low = v;
      default: logic_rail_low = v;
    endcase
  endtask

  task automatic toggle_mute();
    mute_n = 1'b0; step(2);
    mute_n = 1'b1; step(2);
  endtask

  task automatic bring_up(input string req);
    mute_n = 1'b0; step(2);
    mute_n = 1'b1; step(TON + 4);
    #1 chk(req, hiz, 1'b0);
  endtask

  // sweep all PWM codes; expected enables computed from the R2 mapping
  task automatic sweep(input string req, input logic off);
    for (int code = 0; code < (1 << NHB); code++) begin
      logic [NHB-1:0] exp_hs, exp_ls;
      for (int c = 0; c < NCH; c++) begin
        pwm_p[c] = code[2*c];
        pwm_n[c] = code[2*c+1];
        exp_hs[2*c]   = off ? 1'b0 : code[2*c];
        exp_ls[2*c]   = off ? 1'b0 : ~code[2*c];
        exp_hs[2*c+1] = off ? 1'b0 : code[2*c+1];
        exp_ls[2*c+1] = off ? 1'b0 : ~code[2*c+1];
      end
      #1;
      chk({req, " hs"}, hs_en, exp_hs);
      chk({req, " ls"}, ls_en, exp_ls);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    #1;
    chk("R1 reset hiz", hiz, 1'b1);
    chk("R1 reset gates", {hs_en, ls_en}, '0);
    chk("R5 reset err", err_pull, 1'b0);
    chk("R8 reset warn", warn_pull, 1'b0);

    // R3: awake but muted stays off
    standby_n = 1'b1; step(20);
    #1 chk("R3 awake muted hiz", hiz, 1'b1);

    // R4: exact turn-on edge
    mute_n = 1'b1;
    step(TON);
    #1 chk("R4 still ramping", hiz, 1'b1);
    step(1);
    #1 chk("R4 live after delay", hiz, 1'b0);

    // R2: full decode table while running
    sweep("R2 decode", 1'b0);

    // R1: mute low blocks every code at once
    mute_n = 1'b0;
    #1 chk("R1 mute immediate hiz", hiz, 1'b1);
    sweep("R1 muted", 1'b1);
    pwm_p = '0; pwm_n = '0;

    // R3: standby and wake with mute held high
    bring_up("R4 bring up");
    standby_n = 1'b0;
    #1 chk("R3 standby hiz", hiz, 1'b1);
    step(5);
    standby_n = 1'b1;
    step(TON + 1);
    #1 chk("R3 wake delay", hiz, 1'b1);
    step(1);
    #1 chk("R3 wake live", hiz, 1'b0);

    // R7: filter boundary on overcurrent
    over_cur = 1'b1; step(FLT - 1); over_cur = 1'b0; step(12);
    #1 chk("R7 short pulse err", err_pull, 1'b0);
    chk("R7 short pulse hiz", hiz, 1'b0);
    over_cur = 1'b1; step(FLT); over_cur = 1'b0; step(12);
    #1 chk("R7 full pulse err", err_pull, 1'b1);
    toggle_mute();
    #1 chk("R6 cleared after r7", err_pull, 1'b0);
    bring_up("R6 recover after r7");

    // R5 / R6 per fault source
    for (int s = 0; s < 4; s++) begin
      set_fault(s, 1'b1); step(FLT + 4);
      set_fault(s, 1'b0); step(6);
      #1 chk("R5 err latched", err_pull, 1'b1);
      chk("R5 hiz on fault", hiz, 1'b1);
      step(20);
      #1 chk("R6 err held", err_pull, 1'b1);
      toggle_mute();
      #1 chk("R6 err cleared", err_pull, 1'b0);
      bring_up("R6 relive");
      // persistent fault re-latches through a toggle
      set_fault(s, 1'b1); step(FLT + 4);
      toggle_mute(); step(2);
      #1 chk("R6 relatch", err_pull, 1'b1);
      set_fault(s, 1'b0); step(6);
      toggle_mute();
      bring_up("R6 relive2");
    end

    // R10: a missing rail blocks turn-on across toggles
    logic_rail_low = 1'b1; step(FLT + 4);
    for (int t = 0; t < 3; t++) begin
      toggle_mute(); step(TON + 4);
      #1 chk("R10 rail low hiz", hiz, 1'b1);
    end
    logic_rail_low = 1'b0; pwr_rail_low = 1'b1; step(FLT + 4);
    toggle_mute(); step(TON + 4);
    #1 chk("R10 power rail low hiz", hiz, 1'b1);
    pwr_rail_low = 1'b0; step(6);
    toggle_mute();
    bring_up("R10 recover");

    // R9: fault in the middle of the turn-on delay
    mute_n = 1'b0; step(2);
    mute_n = 1'b1; step(2);
    temp_crit = 1'b1; step(FLT + 2); temp_crit = 1'b0;
    step(TON + 10);
    #1 chk("R9 err", err_pull, 1'b1);
    chk("R9 stays off", hiz, 1'b1);
    toggle_mute();
    bring_up("R9 recover");

    // R8: warning hysteresis
    temp_hot = 1'b1; step(FLT + 2); temp_hot = 1'b0; step(6);
    #1 chk("R8 warn set", warn_pull, 1'b1);
    chk("R8 still live", hiz, 1'b0);
    chk("R8 no error", err_pull, 1'b0);
    step(20);
    #1 chk("R8 warn held in band", warn_pull, 1'b1);
    temp_cool = 1'b1; step(FLT - 1); temp_cool = 1'b0; step(8);
    #1 chk("R8 short cool ignored", warn_pull, 1'b1);
    temp_cool = 1'b1; step(FLT + 2); temp_cool = 1'b0; step(6);
    #1 chk("R8 warn released", warn_pull, 1'b0);
    chk("R8 live after release", hiz, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule